// File: doc/BRIEF.md
# Interleaved Multiphase PWM Sequencer with Phase Detection

This block drives up to three logic-level PWM outputs for a multiphase buck regulator. A master tick input, one clock cycle wide, marks each cycle of the master oscillator. Each tick starts the switching period of the next enabled phase, so the phases are interleaved in round-robin order. As a result, each phase switches at the master rate divided by the number of enabled phases. Each phase has its own duty request, given in system clock cycles. The block captures that request at the start of the phase's own period and holds the output high for exactly that many cycles. Because each phase is timed on its own, pulses from different phases may overlap, and a long request can keep a phase high almost all the time.

At start-up the block runs a short detection step. While the window strobe is high, the first two ticks sample the sensed level of the last phase pin. If the pin reads high on both of those ticks, the block drops that phase and runs with two phases. It also clears that phase's output enable, so the pad buffer places the pin in high impedance. The detection result is held until the next reset. Until detection ends, every output is held low and every output enable stays set.

Top module: `mpwm_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it, every `pwm_o` bit is 0, every `pwm_oe_o` bit is 1, and `nact_o` equals 3.
- R2: Ticks that arrive before two detection ticks have been seen do not start any phase, and all `pwm_o` bits stay 0.
- R3: If `sense_i` is 1 on both detection ticks (ticks with `det_win_i` high), then from the cycle after the second detection tick `nact_o` is 2 and `pwm_oe_o[2]` is 0.
- R4: If `sense_i` is 0 on either detection tick, the block stays at three phases, with `nact_o` equal to 3 and `pwm_oe_o` equal to 3'b111.
- R5: Once detection has finished, later ticks with `det_win_i` high do not change `nact_o` or `pwm_oe_o` until the next reset, whatever the level of `sense_i`.
- R6: The first tick after detection starts phase 0. Each later tick starts the next enabled phase in ascending order, wrapping back to 0, and a dropped phase is skipped.
- R7: A phase started by a tick with duty request d has its `pwm_o` bit high for exactly d clock cycles, beginning in the cycle after that tick. A request of 0 gives no pulse.
- R8: A change to a phase's duty request during its period has no effect until that phase's next start.
- R9: Phases may be high at the same time. If a phase restarts while still high, it stays high and begins counting the new request.
- R10: A dropped phase keeps its `pwm_o` bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle master oscillator tick |
| det_win_i | input | 1 | Detection window strobe; ticks during it are detection ticks |
| sense_i | input | 1 | Sensed level of the last phase pin |
| duty_i | input | NPH*DW (3x8) | Per-phase duty request in clock cycles |
| pwm_o | output | NPH (3) | PWM outputs, one per phase |
| pwm_oe_o | output | NPH (3) | Output enables; 0 means the pin is high impedance |
| nact_o | output | $clog2(NPH+1) (2) | Number of active phases |

## Verification
A wrong rotation pointer shows up at the next tick, when the wrong `pwm_o` bit rises. A wrong remaining-cycle count shows as a pulse that ends early or late, within one duty request of its start. A faulty detection latch shows in `nact_o` and `pwm_oe_o` in the cycle after the second detection tick, or as a change on a later window strobe. The bench model predicts every output in every cycle, so each of these faults is caught in the cycle where it first appears.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

  // Progress of the start-up phase sensing
  typedef enum logic {
    DET_SAMPLING = 1'b0,
    DET_DONE     = 1'b1
  } det_state_e;

endpackage

// File: rtl/mpwm_detect.sv
module mpwm_detect
  import mpwm_pkg::*;
#(
  parameter int DET_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic win_i,
  input  logic pin_i,
  output logic done_o,
  output logic drop_o
);

  localparam int CW = $clog2(DET_TICKS + 1);

  det_state_e     state;
  logic [CW-1:0]  seen;
  logic           all_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= DET_SAMPLING;
      seen   <= '0;
      all_hi <= 1'b1;
      drop_o <= 1'b0;
    end else if (state == DET_SAMPLING && tick_i && win_i) begin
      // Every detection tick must see the pin high for the phase to be dropped
      all_hi <= all_hi & pin_i;
      seen   <= seen + CW'(1);
      if (seen == CW'(DET_TICKS - 1)) begin
        state  <= DET_DONE;
        drop_o <= all_hi & pin_i;
      end
    end
  end

  assign done_o = (state == DET_DONE);

endmodule

// File: rtl/mpwm_rotor.sv
module mpwm_rotor #(
  parameter int NPH = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick_i,
  input  logic                       run_i,
  input  logic [$clog2(NPH+1)-1:0]   nact_i,
  output logic [NPH-1:0]             start_o
);

  localparam int PW = (NPH > 1) ? $clog2(NPH) : 1;

  logic [PW-1:0] ptr;

  // One start pulse per tick, on the phase the pointer names
  for (genvar i = 0; i < NPH; i++) begin : g_start
    assign start_o[i] = run_i && tick_i && (ptr == PW'(i));
  end

  // Only the highest phase can be dropped, so enabled phases are 0..nact-1
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (run_i && tick_i) begin
      if (int'(ptr) + 1 >= int'(nact_i)) ptr <= '0;
      else                               ptr <= ptr + PW'(1);
    end
  end

endmodule

// File: rtl/mpwm_channel.sv
module mpwm_channel #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [DW-1:0] duty_i,
  output logic          pwm_o
);

  logic [DW-1:0] rem;

  // Duty is taken only at the period start; rem counts the cycles left high
  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      pwm_o <= 1'b0;
    end else if (start_i) begin
      rem   <= duty_i;
      pwm_o <= (duty_i != '0);
    end else begin
      if (rem != '0) rem <= rem - DW'(1);
      pwm_o <= (rem > DW'(1));
    end
  end

endmodule

// File: rtl/mpwm_sequencer.sv
module mpwm_sequencer #(
  parameter int NPH       = 3,
  parameter int DW        = 8,
  parameter int DET_TICKS = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick_i,
  input  logic                     det_win_i,
  input  logic                     sense_i,
  input  logic [NPH-1:0][DW-1:0]   duty_i,
  output logic [NPH-1:0]           pwm_o,
  output logic [NPH-1:0]           pwm_oe_o,
  output logic [$clog2(NPH+1)-1:0] nact_o
);

  localparam int CNTW = $clog2(NPH + 1);

  logic           det_done;
  logic           det_drop;
  logic [NPH-1:0] start_vec;

  mpwm_detect #(.DET_TICKS(DET_TICKS)) u_detect (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_i),
    .win_i  (det_win_i),
    .pin_i  (sense_i),
    .done_o (det_done),
    .drop_o (det_drop)
  );

  assign nact_o = det_drop ? CNTW'(NPH - 1) : CNTW'(NPH);

  mpwm_rotor #(.NPH(NPH)) u_rotor (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_i),
    .run_i   (det_done),
    .nact_i  (nact_o),
    .start_o (start_vec)
  );

  for (genvar i = 0; i < NPH; i++) begin : g_phase
    mpwm_channel #(.DW(DW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .start_i (start_vec[i]),
      .duty_i  (duty_i[i]),
      .pwm_o   (pwm_o[i])
    );
    // Only the sensed (last) phase can lose its driver
    if (i == NPH - 1) begin : g_sensed
      assign pwm_oe_o[i] = ~det_drop;
    end else begin : g_fixed
      assign pwm_oe_o[i] = 1'b1;
    end
  end

endmodule

// File: rtl/mpwm_sequencer_chk.sv
module mpwm_sequencer_chk #(
  parameter int NPH = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NPH-1:0]           pwm_o,
  input logic [NPH-1:0]           pwm_oe_o,
  input logic [$clog2(NPH+1)-1:0] nact_o,
  input logic                     det_done,
  input logic [NPH-1:0]           start_vec
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pwm_o == '0 && pwm_oe_o == '1 && int'(nact_o) == NPH));

  assert_quiet_before_detect_R2: assert property (@(posedge clk) disable iff (rst)
    !det_done |-> pwm_o == '0);

  assert_drop_tristates_R3: assert property (@(posedge clk) disable iff (rst)
    (int'(nact_o) == NPH - 1) |-> !pwm_oe_o[NPH-1]);

  assert_result_latched_R5: assert property (@(posedge clk) disable iff (rst)
    (det_done && $past(det_done)) |-> ($stable(nact_o) && $stable(pwm_oe_o)));

  assert_single_start_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(start_vec));

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    assert_rise_after_start_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(pwm_o[i]) |-> $past(start_vec[i]));
  end

  assert_dropped_low_R10: assert property (@(posedge clk) disable iff (rst)
    !pwm_oe_o[NPH-1] |-> !pwm_o[NPH-1]);

endmodule

bind mpwm_sequencer mpwm_sequencer_chk #(.NPH(NPH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pwm_o     (pwm_o),
  .pwm_oe_o  (pwm_oe_o),
  .nact_o    (nact_o),
  .det_done  (det_done),
  .start_vec (start_vec)
);

// File: tb/test_mpwm_sequencer.sv
`timescale 1ns/1ps
module test_mpwm_sequencer;

  localparam int NPH = 3;
  localparam int DW  = 8;
  localparam int TP  = 8;   // clocks between master ticks

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   tick = 1'b0;
  logic                   det_win = 1'b0;
  logic                   sense = 1'b0;
  logic [NPH-1:0][DW-1:0] duty = '0;
  logic [NPH-1:0]         pwm;
  logic [NPH-1:0]         oe;
  logic [1:0]             nact;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  string tag = "R1";

  always #2 clk = ~clk;   // 250 MHz

  mpwm_sequencer #(.NPH(NPH), .DW(DW), .DET_TICKS(2)) i_mpwm_sequencer (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .det_win_i (det_win),
    .sense_i   (sense),
    .duty_i    (duty),
    .pwm_o     (pwm),
    .pwm_oe_o  (oe),
    .nact_o    (nact)
  );

  // Free-running master tick, one cycle wide every TP clocks
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % TP;
    tick <= (tcnt == 0);
  end

  // Behavioural reference model
  int  cyc = 0;
  bit  m_done, m_drop;
  int  m_hc, m_rr;
  bit  m_hall;
  int  m_st[NPH];
  int  m_dq[NPH];
  bit  e_pwm[NPH];
  bit  e_oe[NPH];
  int  e_nact;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_done = 0; m_drop = 0; m_hc = 0; m_hall = 1; m_rr = 0;
      for (int i = 0; i < NPH; i++) begin m_st[i] = -100000; m_dq[i] = 0; end
    end else begin
      // R6: a tick after detection starts the next phase in rotation
      if (tick && m_done) begin
        m_st[m_rr] = cyc;
        m_dq[m_rr] = int'(duty[m_rr]);   // R8: captured only here
        m_rr = (m_rr + 1) % (m_drop ? NPH - 1 : NPH);
      end
      if (tick && det_win && !m_done) begin
        m_hc++;
        m_hall = m_hall & sense;
        if (m_hc == 2) begin m_done = 1; m_drop = m_hall; end
      end
    end
    for (int i = 0; i < NPH; i++) begin
      e_pwm[i] = (cyc - m_st[i]) < m_dq[i];   // R7/R9
      e_oe[i]  = !(m_drop && i == NPH - 1);
    end
    e_nact = m_drop ? NPH - 1 : NPH;
  end

  // Per-cycle compare, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      for (int i = 0; i < NPH; i++) begin
        checks++;
        if (pwm[i] !== e_pwm[i]) begin
          errors++;
          $display("FAIL %s pwm[%0d] cyc %0d: actual=%0b expected=%0b", tag, i, cyc, pwm[i], e_pwm[i]);
        end
        checks++;
        if (oe[i] !== e_oe[i]) begin
          errors++;
          $display("FAIL R3 oe[%0d] cyc %0d: actual=%0b expected=%0b", i, cyc, oe[i], e_oe[i]);
        end
      end
      checks++;
      if (int'(nact) != e_nact) begin
        errors++;
        $display("FAIL R4 nact cyc %0d: actual=%0d expected=%0d", cyc, nact, e_nact);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Return at the negedge after the next tick has been sampled
  task automatic next_tick();
    do @(posedge clk); while (!tick);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) next_tick();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    // ---- Scenario A: three phases kept ----
    tag = "R1";
    repeat (4) @(negedge clk);
    check("R1 pwm", int'(pwm), 0);
    check("R1 oe", int'(oe), 7);
    check("R1 nact", int'(nact), 3);
    rst = 1'b0;
    tag = "R2";
    duty[0] = 8'd5; duty[1] = 8'd5; duty[2] = 8'd5;
    ticks(3);                       // R2: ticks without window ignored
    check("R2 quiet", int'(pwm), 0);
    det_win = 1'b1; sense = 1'b1;
    next_tick();
    sense = 1'b0;                   // R4: high on only one detection tick
    next_tick();
    det_win = 1'b0;
    check("R4 nact", int'(nact), 3);
    check("R4 oe", int'(oe), 7);
    tag = "R7";
    duty[0] = 8'd3; duty[1] = 8'd10; duty[2] = 8'd0;
    ticks(4);
    tag = "R9";
    duty[1] = 8'd30;                // longer than the 24-cycle phase period
    ticks(3);
    tag = "R8";
    duty[0] = 8'd6;
    do next_tick(); while (m_rr != 1);  // phase 0 just started with 6
    duty[0] = 8'd15;                // mid-period change, takes effect next start
    ticks(6);
    tag = "R5";
    det_win = 1'b1; sense = 1'b1;
    ticks(3);
    det_win = 1'b0;
    check("R5 nact", int'(nact), 3);
    check("R5 oe", int'(oe), 7);

    // ---- Scenario B: last phase sensed high ----
    @(negedge clk); rst = 1'b1; tag = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R3";
    det_win = 1'b1; sense = 1'b1;
    ticks(2);
    det_win = 1'b0; sense = 1'b0;
    check("R3 nact", int'(nact), 2);
    check("R3 oe", int'(oe), 3);
    tag = "R6";
    duty[0] = 8'd4; duty[1] = 8'd12; duty[2] = 8'd20;
    next_tick();
    check("R6 first start is phase 0", int'(pwm), 1);
    tag = "R10";
    ticks(8);
    check("R10 dropped low", int'(pwm[2]), 0);
    tag = "R5";
    det_win = 1'b1; sense = 1'b0;
    ticks(2);
    det_win = 1'b0;
    check("R5 nact after late window", int'(nact), 2);
    repeat (3) @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      summary();
      $finish;
    end
  end

endmodule